// File: doc/BRIEF.md
# Shared Activity-LED and EEPROM-Clock Pin with Presence Detect

This block controls a single board pin that does three jobs. In normal operation it drives a status LED that reflects receive activity on the network, with the LED's function and polarity set by configuration bits. When the serial EEPROM interface is in use, the same pin carries the EEPROM serial clock. At the end of reset, the pin is left undriven for one more clock so that an external pull resistor sets its level. That level is captured into a presence flag: high means an EEPROM is fitted, and low means none is fitted.

The level the pin shows while it is released is brought in as `pin_sample`. The block produces a drive value and a drive enable for the pad. Short receive pulses are stretched to a fixed minimum width so that they can be seen on the LED. The stretch can be retriggered: a new pulse restarts the full width.

LED function codes on `led_fn` are as follows:
- `00`: stretched receive activity (the default).
- `01`: receive activity delayed by one register, with no stretch.
- `10`: LED forced off.
- `11`: LED forced on.

With `led_pol` = 0 the LED is active low, which is the default. With `led_pol` = 1 it is active high.

Top module: `led_eeclk_pin`

## Requirements
- R1: While `rst_n` is low, `pin_oe`, `pin_out` and `eedet` are all 0.
- R2: At the first rising clock edge with `rst_n` high, `eedet` takes the level of `pin_sample`. `pin_oe` stays 0 until after that edge and is 1 from then on until the next reset.
- R3: A captured high level gives `eedet` = 1 (EEPROM present), and a captured low level gives `eedet` = 0 (no EEPROM).
- R4: After capture, `eedet` does not change whatever `pin_sample` does, until `rst_n` goes low again.
- R5: While `pin_oe` = 1 and `ee_en` = 1, `pin_out` follows `ee_clk` in the same cycle, whatever the LED configuration.
- R6: While `pin_oe` = 1 and `ee_en` = 0, `pin_out` equals the LED-on state when `led_pol` = 1, and its inverse when `led_pol` = 0.
- R7: With `led_fn` = `00`, a clock edge that samples `rx_act` high turns the LED on for exactly HOLD_CYC cycles after that edge. Another sampled pulse restarts the full HOLD_CYC count.
- R8: With `led_fn` = `01`, the LED-on state equals the `rx_act` level sampled at the previous clock edge.
- R9: With `led_fn` = `10` the LED is off, and with `led_fn` = `11` it is on.
- R10: With all configuration inputs at 0 and no receive activity, the released pin (`pin_oe` = 1) is driven high, which is the LED-off level for an active-low LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_act | input | 1 | Receive-activity indication |
| ee_en | input | 1 | EEPROM interface active; selects the serial clock onto the pin |
| ee_clk | input | 1 | Requested EEPROM serial clock level |
| led_fn | input | 2 | LED function code (00 stretched rx, 01 raw rx, 10 off, 11 on) |
| led_pol | input | 1 | LED polarity (0 active low, 1 active high) |
| pin_sample | input | 1 | Level present on the pin while it is released |
| pin_out | output | 1 | Pin drive value (0 while not driven) |
| pin_oe | output | 1 | Pin drive enable |
| eedet | output | 1 | Latched EEPROM-present flag |

## Verification
The bench aims at the one-cycle capture window after reset. A design that drives the pin during that cycle, or samples a cycle late, would latch the wrong level when `pin_sample` changes right after release. It also drives resets in the middle of a run to check that `eedet` is recaptured rather than kept, and it moves `pin_sample` freely after capture to catch a flag that keeps re-sampling. Single receive pulses are counted against HOLD_CYC to expose an off-by-one in the stretch, and back-to-back pulses expose a counter that fails to restart. Random switching of `ee_en`, function and polarity checks the mux priority and the polarity inversion.

// File: rtl/led_pin_pkg.sv
package led_pin_pkg;

  typedef enum logic [1:0] {
    LF_RX_STRETCH = 2'b00,
    LF_RX_RAW     = 2'b01,
    LF_OFF        = 2'b10,
    LF_ON         = 2'b11
  } led_fn_e;

  // LED-on state for a given function code
  function automatic logic led_on_sel(led_fn_e fn, logic held, logic raw);
    case (fn)
      LF_RX_STRETCH: return held;
      LF_RX_RAW:     return raw;
      LF_OFF:        return 1'b0;
      default:       return 1'b1;
    endcase
  endfunction

  // Electrical level for an LED state under the chosen polarity
  function automatic logic led_level(logic on, logic act_high);
    return act_high ? on : ~on;
  endfunction

endpackage

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_act,
  output logic act_hold,
  output logic act_raw
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      act_raw  <= 1'b0;
    end else begin
      act_raw <= rx_act;
      if (rx_act)
        hold_cnt <= HOLD_V;
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign act_hold = (hold_cnt != '0);

endmodule

// File: rtl/eedet_capture.sv
module eedet_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sample,
  output logic eedet,
  output logic drive_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eedet    <= 1'b0;
      drive_en <= 1'b0;
    end else if (!drive_en) begin
      eedet    <= pin_sample;
      drive_en <= 1'b1;
    end
  end
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import led_pin_pkg::*;
(
  input  logic    drive_en,
  input  logic    ee_en,
  input  logic    ee_clk,
  input  led_fn_e fn,
  input  logic    act_high,
  input  logic    act_hold,
  input  logic    act_raw,
  output logic    led_on,
  output logic    pin_out
);
  always_comb begin
    led_on = led_on_sel(fn, act_hold, act_raw);
    if (!drive_en)
      pin_out = 1'b0;
    else if (ee_en)
      pin_out = ee_clk;
    else
      pin_out = led_level(led_on, act_high);
  end
endmodule

// File: rtl/led_eeclk_pin.sv
module led_eeclk_pin
  import led_pin_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_act,
  input  logic       ee_en,
  input  logic       ee_clk,
  input  logic [1:0] led_fn,
  input  logic       led_pol,
  input  logic       pin_sample,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       eedet
);
  logic    act_hold;
  logic    act_raw;
  logic    led_on;
  logic    drive_en;
  led_fn_e fn_sel;

  assign fn_sel = led_fn_e'(led_fn);
  assign pin_oe = drive_en;

  act_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_act   (rx_act),
    .act_hold (act_hold),
    .act_raw  (act_raw)
  );

  eedet_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_sample (pin_sample),
    .eedet      (eedet),
    .drive_en   (drive_en)
  );

  pin_mux u_mux (
    .drive_en (drive_en),
    .ee_en    (ee_en),
    .ee_clk   (ee_clk),
    .fn       (fn_sel),
    .act_high (led_pol),
    .act_hold (act_hold),
    .act_raw  (act_raw),
    .led_on   (led_on),
    .pin_out  (pin_out)
  );

endmodule

// File: rtl/led_eeclk_chk.sv
module led_eeclk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_act,
  input logic       ee_en,
  input logic       ee_clk,
  input logic [1:0] led_fn,
  input logic       led_pol,
  input logic       pin_sample,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       eedet,
  input logic       act_hold,
  input logic       act_raw,
  input logic       led_on
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!pin_oe && !pin_out && !eedet));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> (eedet == $past(pin_sample)));

  assert_eedet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && $past(pin_oe)) |-> $stable(eedet));

  assert_eeclk_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && ee_en) |-> (pin_out == ee_clk));

  assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !ee_en) |-> (pin_out == (led_pol ? led_on : !led_on)));

  assert_stretch_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |=> act_hold);

  assert_stretch_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_hold) |-> !$past(rx_act));

  assert_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |=> act_raw);

  assert_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !ee_en && led_fn[1]) |-> (pin_out == (led_fn[0] ~^ led_pol)));
endmodule

bind led_eeclk_pin led_eeclk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_act     (rx_act),
  .ee_en      (ee_en),
  .ee_clk     (ee_clk),
  .led_fn     (led_fn),
  .led_pol    (led_pol),
  .pin_sample (pin_sample),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .eedet      (eedet),
  .act_hold   (act_hold),
  .act_raw    (act_raw),
  .led_on     (led_on)
);

// File: tb/led_eeclk_pin_tb.sv
module led_eeclk_pin_tb;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_act;
  logic       ee_en;
  logic       ee_clk;
  logic [1:0] led_fn;
  logic       led_pol;
  logic       pin_sample;
  logic       pin_out;
  logic       pin_oe;
  logic       eedet;

  int total = 0;
  int bad   = 0;
  bit done_flag = 1'b0;

  // reference state
  int m_cnt;
  bit m_raw, m_done, m_eedet;

  always #10 clk = ~clk;

  led_eeclk_pin #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .ee_en(ee_en), .ee_clk(ee_clk),
    .led_fn(led_fn), .led_pol(led_pol), .pin_sample(pin_sample),
    .pin_out(pin_out), .pin_oe(pin_oe), .eedet(eedet)
  );

  function automatic bit exp_on(logic [1:0] fn, int cnt, bit raw);
    if (fn == 2'b00) return cnt > 0;
    if (fn == 2'b01) return raw;
    return fn[0];
  endfunction

  function automatic bit exp_pin();
    if (!m_done) return 1'b0;
    if (ee_en) return ee_clk;
    return led_pol ? exp_on(led_fn, m_cnt, m_raw) : !exp_on(led_fn, m_cnt, m_raw);
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // advance to the next negative edge and apply the edge that just passed
  task automatic tick();
    @(negedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_raw = 0; m_done = 0; m_eedet = 0;
    end else begin
      if (!m_done) begin m_eedet = pin_sample; m_done = 1; end
      m_raw = rx_act;
      if (rx_act) m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt--;
    end
  endtask

  task automatic check_all();
    string tag;
    #1;
    if (!rst_n) begin
      m_cnt = 0; m_raw = 0; m_done = 0; m_eedet = 0;
    end
    if (!rst_n) tag = "R1";
    else if (!m_done) tag = "R2";
    else if (ee_en) tag = "R5";
    else if (led_fn == 2'b00) tag = "R7 R6";
    else if (led_fn == 2'b01) tag = "R8 R6";
    else tag = "R9 R6";
    chk(pin_out, exp_pin(), tag);
    chk(pin_oe, m_done, rst_n ? "R2" : "R1");
    chk(eedet, m_eedet, rst_n ? "R3/R4" : "R1");
  endtask

  initial begin
    int seed;
    int rst_hold;
    int hi_cnt;
    seed = $urandom(32'h5EED1);
    rst_n = 0; rx_act = 0; ee_en = 0; ee_clk = 0;
    led_fn = 2'b00; led_pol = 0; pin_sample = 1;
    m_cnt = 0; m_raw = 0; m_done = 0; m_eedet = 0;
    check_all();
    repeat (3) begin tick(); check_all(); end

    // R3: pull-up present -> eedet 1; pin then drops (R4 hold)
    rst_n = 1; check_all();
    tick(); pin_sample = 0; check_all();
    chk(eedet, 1'b1, "R3");
    // R10: defaults, idle, released pin driven high
    tick(); check_all();
    chk(pin_oe, 1'b1, "R10");
    chk(pin_out, 1'b1, "R10");
    repeat (5) begin tick(); pin_sample = ~pin_sample; check_all(); end
    chk(eedet, 1'b1, "R4");

    // R3: pull-down -> eedet 0 after a second reset
    tick(); rst_n = 0; pin_sample = 0; check_all();
    tick(); check_all();
    tick(); rst_n = 1; check_all();
    tick(); pin_sample = 1; check_all();
    chk(eedet, 1'b0, "R3");

    // R7: single pulse, count lit cycles, active high
    led_pol = 1;
    repeat (HOLD + 2) begin tick(); check_all(); end
    tick(); rx_act = 1; check_all();
    tick(); rx_act = 0; check_all();
    hi_cnt = 0;
    for (int i = 0; i < HOLD + 4; i++) begin
      if (pin_out) hi_cnt++;
      tick(); check_all();
    end
    chk(hi_cnt == HOLD, 1'b1, "R7");

    // R7: retrigger in the middle of the hold
    tick(); rx_act = 1; check_all();
    tick(); rx_act = 0; check_all();
    repeat (HOLD - 3) begin tick(); check_all(); end
    tick(); rx_act = 1; check_all();
    tick(); rx_act = 0; check_all();
    repeat (HOLD - 1) begin tick(); check_all(); end
    chk(pin_out, 1'b1, "R7");
    tick(); check_all();
    chk(pin_out, 1'b0, "R7");

    // R5: clock passthrough overrides forced-on LED
    led_fn = 2'b11; ee_en = 1;
    for (int i = 0; i < 6; i++) begin
      tick(); ee_clk = i[0]; check_all();
      chk(pin_out, ee_clk, "R5");
    end
    ee_en = 0;

    // random phase
    rst_hold = 0;
    for (int i = 0; i < 3000; i++) begin
      tick();
      if (rst_hold > 0) begin
        rst_hold--;
        rst_n = (rst_hold == 0);
      end else if ($urandom_range(399) == 0) begin
        rst_n = 0; rst_hold = 3;
      end
      rx_act = ($urandom_range(5) == 0);
      if ($urandom_range(15) == 0) ee_en = ~ee_en;
      ee_clk = $urandom_range(1);
      if ($urandom_range(49) == 0) led_fn = 2'($urandom_range(3));
      if ($urandom_range(49) == 0) led_pol = ~led_pol;
      pin_sample = $urandom_range(1);
      check_all();
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule